// File: doc/BRIEF.md
# Hierarchical Address Translation Walker

This block turns a virtual address into a real address by reading translation tables from memory, one 8-byte entry per level. A request carries a virtual address, an access kind and an address-space selector. The selector picks one of three table designators (primary, secondary, home). The designator names the type of the top table, so a walk visits between two and five tables: up to four region levels, then a segment table, then a page table. A designator can also mark its space as real, in which case no table is read at all. When translation is switched off, the address passes through unchanged.

The walker handles one request at a time. While a walk is running it raises `busy` and ignores new requests. For each table entry it holds a read request on a simple memory port until the port answers with a valid strobe. Every request produces exactly one response pulse. The response carries either a real address with read/write/execute rights, or a fault code with a fault word. The fault word is the page-aligned virtual address with a space code and a protection flag in its low bits. The walker has no translation cache and no large-page support.

Top module: `ptw_walker`

## Requirements
- R1: While reset is held and just after it, `busy`, `mem_rd_en` and `rsp_valid` are low.
- R2: With `dat_en` low, an accepted request answers on the next cycle with `rsp_real` equal to `req_va`, `rsp_perm` equal to 3'b111 (bit 2 read, bit 1 write, bit 0 execute) and `rsp_fault` 0. It makes no memory read, and the fault word is zero whenever the fault is 0.
- R3: Designator bits [3:2] give the top table type: 3 region-first, 2 region-second, 1 region-third, 0 segment. For type 2, va[63:53] must be zero. For type 1, va[63:42] must be zero. For type 0, va[63:31] must be zero. A violation answers at once with fault 4 (specification), makes no read, and gives fault word {va[63:12], 9'b0, 1'b0, space code}. The space code is 1 for primary, 2 for secondary and 3 for home.
- R4: When designator bit 5 (real space) is set and the range check passes, the request answers at once with `rsp_real` = `req_va`, makes no read, and gets full rights, subject to R10.
- R5: The walk starts at the table named by the designator, with the origin taken from designator bits [63:12]. The read address is origin + 8 × index. The index is va[63:53] for region-first, va[52:42] for region-second, va[41:31] for region-third, va[30:20] for segment and va[19:12] for page. The next origin is the entry with its low 12 bits cleared. `mem_rd_addr` stays stable while `mem_rd_en` waits for `mem_rd_valid`.
- R6: A region or segment entry with bit 5 set ends the walk with fault 2 (segment translation) and a fault word as in R3.
- R7: A region entry from a type-k table must carry type k-1 in bits [3:2], and a segment entry must carry type 0. A mismatch ends the walk with fault 4.
- R8: A page entry with bit 10 set ends the walk with fault 3 (page translation). Otherwise `rsp_real` is entry[63:12] joined with va[11:0]. Bit 9 of the page entry removes the write right.
- R9: A write (kind 1) to a page without write right gives fault 1 (protection). Its fault word has bit 2 set and the space code in bits [1:0].
- R10: Space selector 0 is primary, 1 is secondary, 2 is home, and 3 acts as primary. Kind 0 is read, 1 is write and 2 is instruction fetch. With secondary selected, a fetch translates through the primary designator, uses space code 1 and keeps only the execute right. A data access translates through the secondary designator and loses the execute right.
- R11: While `busy` is high, `req_valid` is ignored. Only one walk runs at a time, and each request yields exactly one `rsp_valid` pulse.
- R12: The range check has priority over the real-space bypass. At each region or segment level, the invalid check has priority over the type check.
- R13: Whenever `rsp_fault` is nonzero, `rsp_real` and `rsp_perm` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dat_en | input | 1 | Translation enable, sampled when a request is accepted |
| req_valid | input | 1 | Request strobe, accepted when `busy` is low |
| req_va | input | 64 | Virtual address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_space | input | 2 | Space selector: 0 primary, 1 secondary, 2 home |
| desig_pri | input | 64 | Primary table designator |
| desig_sec | input | 64 | Secondary table designator |
| desig_home | input | 64 | Home table designator |
| busy | output | 1 | A walk is in progress |
| mem_rd_en | output | 1 | Table read request, held until `mem_rd_valid` |
| mem_rd_addr | output | 64 | Table entry byte address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 64 | Table entry |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_real | output | 64 | Real address |
| rsp_perm | output | 3 | Rights {read, write, execute} |
| rsp_fault | output | 3 | 0 none, 1 protection, 2 segment, 3 page, 4 specification |
| rsp_fault_word | output | 64 | Page-aligned VA, protection flag, space code |

## Verification
The bench aims at the boundaries of the range check: the largest address a segment-topped space accepts, one past it, and a real-space designator that must still fault because its address is out of range. A design that ordered these checks wrong would either translate an illegal address or reject a legal one. It also reads an unmapped region-first slot, where a zero entry must fail the type check and not the invalid check. It covers the secondary space's split between fetch and data, where a wrong designator choice shows up as a different real address and wrong rights. Finally, it drives a request while a walk is running, which a walker that does not guard `busy` would answer with a spurious second response. It also counts table reads per request, so that a walk starting at the wrong level, or a bypass that still reads memory, is caught.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
   typedef enum logic [1:0] {SP_PRI = 2'd0, SP_SEC = 2'd1, SP_HOME = 2'd2, SP_ALT = 2'd3} space_e;
   typedef enum logic [1:0] {AK_READ = 2'd0, AK_WRITE = 2'd1, AK_FETCH = 2'd2, AK_RSVD = 2'd3} kind_e;
   typedef enum logic [2:0] {
      FLT_NONE = 3'd0, FLT_PROT = 3'd1, FLT_SEGX = 3'd2, FLT_PAGEX = 3'd3, FLT_SPEC = 3'd4
   } fault_e;
   localparam int TYPE_LSB   = 2;
   localparam int ENT_INV    = 5;
   localparam int REAL_SPACE = 5;
   localparam int PG_RO      = 9;
   localparam int PG_INV     = 10;
endpackage

// File: rtl/ptw_index.sv
module ptw_index #(
   parameter int ADDR_W      = 64,
   parameter int PAGE_SHIFT  = 12,
   parameter int PT_IDX_W    = 8,
   parameter int TBL_IDX_W   = 11,
   parameter int ENTRY_SHIFT = 3,
   parameter int NLVL        = 5,
   parameter int LVL_W       = 3
) (
   input  logic [ADDR_W-1:0] va,
   input  logic [LVL_W-1:0]  lvl,
   input  logic [ADDR_W-1:0] origin,
   output logic [ADDR_W-1:0] entry_addr,
   output logic              va_fits
);
   logic [ADDR_W-1:0] offs [NLVL];
   logic [NLVL-1:0]   fit_tab;
   logic              unused_va;

   assign unused_va = ^va[PAGE_SHIFT-1:0];

   for (genvar l = 0; l < NLVL; l++) begin : g_lvl
      if (l == 0) begin : g_page
         assign offs[l]    = ADDR_W'(va[PAGE_SHIFT +: PT_IDX_W]) << ENTRY_SHIFT;
         assign fit_tab[l] = 1'b1;
      end else begin : g_tbl
         localparam int LSB = PAGE_SHIFT + PT_IDX_W + (l - 1) * TBL_IDX_W;
         assign offs[l] = ADDR_W'(va[LSB +: TBL_IDX_W]) << ENTRY_SHIFT;
         if (l == NLVL - 1) begin : g_top
            assign fit_tab[l] = 1'b1;
         end else begin : g_rng
            assign fit_tab[l] = (va >> (LSB + TBL_IDX_W)) == '0;
         end
      end
   end

   always_comb begin
      entry_addr = origin;
      va_fits    = 1'b1;
      for (int l = 0; l < NLVL; l++) begin
         if (lvl == LVL_W'(l)) begin
            entry_addr = origin + offs[l];
            va_fits    = fit_tab[l];
         end
      end
   end
endmodule

// File: rtl/ptw_entry_chk.sv
module ptw_entry_chk import ptw_pkg::*; #(
   parameter int ADDR_W     = 64,
   parameter int PAGE_SHIFT = 12,
   parameter int LVL_W      = 3
) (
   input  logic [ADDR_W-1:0] data,
   input  logic [LVL_W-1:0]  lvl,
   output logic [2:0]        flt,
   output logic [ADDR_W-1:0] nxt_origin,
   output logic              ro
);
   logic [1:0] exp_type;
   logic       unused_bits;

   assign unused_bits = ^{data[PAGE_SHIFT-1:PG_INV+1], data[PG_RO-1:ENT_INV+1],
                          data[ENT_INV-1:TYPE_LSB+2], data[TYPE_LSB-1:0]};
   assign exp_type   = (lvl >= LVL_W'(2)) ? 2'(lvl - LVL_W'(2)) : 2'd0;
   assign nxt_origin = {data[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
   assign ro         = data[PG_RO];

   always_comb begin
      flt = FLT_NONE;
      if (lvl == '0) begin
         if (data[PG_INV]) flt = FLT_PAGEX;
      end else if (data[ENT_INV]) begin
         flt = FLT_SEGX;
      end else if (data[TYPE_LSB +: 2] != exp_type) begin
         flt = FLT_SPEC;
      end
   end
endmodule

// File: rtl/ptw_rights.sv
module ptw_rights import ptw_pkg::*; (
   input  logic       ro,
   input  logic [1:0] kind,
   input  logic       sec,
   output logic [2:0] perm,
   output logic       prot
);
   logic wr_ok;
   assign wr_ok = !ro;
   assign prot  = (kind == AK_WRITE) && !wr_ok;

   always_comb begin
      if (!sec)                  perm = {1'b1, wr_ok, 1'b1};
      else if (kind == AK_FETCH) perm = 3'b001;
      else                       perm = {1'b1, wr_ok, 1'b0};
   end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker import ptw_pkg::*; #(
   parameter int ADDR_W      = 64,
   parameter int PAGE_SHIFT  = 12,
   parameter int PT_IDX_W    = 8,
   parameter int TBL_IDX_W   = 11,
   parameter int ENTRY_SHIFT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dat_en,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_va,
   input  logic [1:0]        req_kind,
   input  logic [1:0]        req_space,
   input  logic [ADDR_W-1:0] desig_pri,
   input  logic [ADDR_W-1:0] desig_sec,
   input  logic [ADDR_W-1:0] desig_home,
   output logic              busy,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rd_valid,
   input  logic [ADDR_W-1:0] mem_rd_data,
   output logic              rsp_valid,
   output logic [ADDR_W-1:0] rsp_real,
   output logic [2:0]        rsp_perm,
   output logic [2:0]        rsp_fault,
   output logic [ADDR_W-1:0] rsp_fault_word
);
   localparam int NLVL  = 5;
   localparam int LVL_W = $clog2(NLVL + 1);
   localparam int SPAN  = PAGE_SHIFT + PT_IDX_W + (NLVL - 1) * TBL_IDX_W;

   if (SPAN != ADDR_W) begin : g_bad_span
      $error("index fields must cover the address width exactly");
   end
   if ((1 << ENTRY_SHIFT) * 8 != ADDR_W) begin : g_bad_entry
      $error("entry size must equal the data width");
   end
   if (PAGE_SHIFT <= PG_INV) begin : g_bad_page
      $error("page shift must exceed the entry flag positions");
   end

   logic              busy_q, sec_q, is_sec, use_pri, va_fits, prot;
   logic [LVL_W-1:0]  lvl_q, top_lvl, idx_lvl;
   logic [ADDR_W-1:0] origin_q, va_q, desig, idx_va, entry_addr, nxt_origin;
   logic [1:0]        kind_q, code_q, code_n;
   logic [2:0]        chk_flt, perm;
   logic              chk_ro, unused_desig;

   function automatic logic [ADDR_W-1:0] fword(input logic [ADDR_W-1:0] va,
                                               input logic p, input logic [1:0] code);
      fword = {va[ADDR_W-1:PAGE_SHIFT], {(PAGE_SHIFT-3){1'b0}}, p, code};
   endfunction

   always_comb begin
      is_sec  = req_space == SP_SEC;
      use_pri = (req_space == SP_PRI) || (req_space == SP_ALT) || (is_sec && req_kind == AK_FETCH);
      if (use_pri) begin
         desig = desig_pri;  code_n = 2'd1;
      end else if (is_sec) begin
         desig = desig_sec;  code_n = 2'd2;
      end else begin
         desig = desig_home; code_n = 2'd3;
      end
      top_lvl = LVL_W'(desig[TYPE_LSB +: 2]) + LVL_W'(1);
   end
   assign unused_desig = ^{desig[PAGE_SHIFT-1:REAL_SPACE+1], desig[REAL_SPACE-1:TYPE_LSB+2],
                           desig[TYPE_LSB-1:0]};

   assign idx_va  = busy_q ? va_q : req_va;
   assign idx_lvl = busy_q ? lvl_q : top_lvl;

   ptw_index #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .PT_IDX_W(PT_IDX_W),
               .TBL_IDX_W(TBL_IDX_W), .ENTRY_SHIFT(ENTRY_SHIFT), .NLVL(NLVL), .LVL_W(LVL_W))
      u_idx (.va(idx_va), .lvl(idx_lvl), .origin(origin_q), .entry_addr(entry_addr), .va_fits(va_fits));

   ptw_entry_chk #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .LVL_W(LVL_W))
      u_ent (.data(mem_rd_data), .lvl(lvl_q), .flt(chk_flt), .nxt_origin(nxt_origin), .ro(chk_ro));

   ptw_rights u_rights (.ro(busy_q & chk_ro), .kind(busy_q ? kind_q : req_kind),
                        .sec(busy_q ? sec_q : is_sec), .perm(perm), .prot(prot));

   assign busy        = busy_q;
   assign mem_rd_en   = busy_q;
   assign mem_rd_addr = entry_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0; lvl_q <= '0; origin_q <= '0; va_q <= '0;
         kind_q <= '0; code_q <= '0; sec_q <= 1'b0;
         rsp_valid <= 1'b0; rsp_real <= '0; rsp_perm <= '0;
         rsp_fault <= '0; rsp_fault_word <= '0;
      end else begin
         rsp_valid <= 1'b0;
         if (!busy_q) begin
            if (req_valid) begin
               va_q <= req_va; kind_q <= req_kind; code_q <= code_n; sec_q <= is_sec;
               if (!dat_en) begin
                  rsp_valid <= 1'b1; rsp_real <= req_va; rsp_perm <= 3'b111;
                  rsp_fault <= FLT_NONE; rsp_fault_word <= '0;
               end else if (!va_fits) begin
                  rsp_valid <= 1'b1; rsp_real <= '0; rsp_perm <= '0;
                  rsp_fault <= FLT_SPEC; rsp_fault_word <= fword(req_va, 1'b0, code_n);
               end else if (desig[REAL_SPACE]) begin
                  rsp_valid <= 1'b1; rsp_real <= req_va; rsp_perm <= perm;
                  rsp_fault <= FLT_NONE; rsp_fault_word <= '0;
               end else begin
                  busy_q   <= 1'b1;
                  lvl_q    <= top_lvl;
                  origin_q <= {desig[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
               end
            end
         end else if (mem_rd_valid) begin
            if (chk_flt != FLT_NONE) begin
               busy_q <= 1'b0;
               rsp_valid <= 1'b1; rsp_real <= '0; rsp_perm <= '0;
               rsp_fault <= chk_flt; rsp_fault_word <= fword(va_q, 1'b0, code_q);
            end else if (lvl_q == '0) begin
               busy_q <= 1'b0;
               rsp_valid <= 1'b1;
               if (prot) begin
                  rsp_real <= '0; rsp_perm <= '0;
                  rsp_fault <= FLT_PROT; rsp_fault_word <= fword(va_q, 1'b1, code_q);
               end else begin
                  rsp_real <= {nxt_origin[ADDR_W-1:PAGE_SHIFT], va_q[PAGE_SHIFT-1:0]};
                  rsp_perm <= perm; rsp_fault <= FLT_NONE; rsp_fault_word <= '0;
               end
            end else begin
               lvl_q    <= lvl_q - LVL_W'(1);
               origin_q <= nxt_origin;
            end
         end
      end
   end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
   parameter int ADDR_W     = 64,
   parameter int PAGE_SHIFT = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              mem_rd_en,
   input logic              mem_rd_valid,
   input logic [ADDR_W-1:0] mem_rd_addr,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] rsp_real,
   input logic [2:0]        rsp_perm,
   input logic [2:0]        rsp_fault,
   input logic [ADDR_W-1:0] rsp_fault_word
);
   assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && !mem_rd_valid) |=> (mem_rd_en && $stable(mem_rd_addr)));

   assert_idle_on_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !busy);

   assert_fault_zeroes_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != 3'd0) |-> (rsp_real == '0 && rsp_perm == 3'd0));

   assert_prot_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault == 3'd1) |-> (rsp_fault_word[2] && rsp_fault_word[1:0] != 2'd0));

   assert_walk_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault > 3'd1) |->
         (!rsp_fault_word[2] && rsp_fault_word[1:0] != 2'd0 && rsp_fault_word[PAGE_SHIFT-1:3] == '0));

   assert_clean_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault == 3'd0) |-> rsp_fault_word == '0);
endmodule

bind ptw_walker ptw_walker_chk #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .mem_rd_en(mem_rd_en), .mem_rd_valid(mem_rd_valid),
   .mem_rd_addr(mem_rd_addr), .rsp_valid(rsp_valid), .rsp_real(rsp_real), .rsp_perm(rsp_perm),
   .rsp_fault(rsp_fault), .rsp_fault_word(rsp_fault_word));

// File: tb/tb_ptw_walker.sv
`timescale 1ns/1ps
module tb_ptw_walker;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dat_en, req_valid, busy, mem_rd_en, mem_rd_valid, rsp_valid;
   logic [63:0] req_va, desig_pri, desig_sec, desig_home, mem_rd_addr, mem_rd_data;
   logic [63:0] rsp_real, rsp_fault_word;
   logic [1:0]  req_kind, req_space;
   logic [2:0]  rsp_perm, rsp_fault;

   int n_chk = 0;
   int n_fail = 0;
   int rd_count = 0;
   bit done = 1'b0;
   logic [63:0] mem [logic [63:0]];

   always #4 clk = ~clk;

   ptw_walker dut (
      .clk(clk), .rst_n(rst_n), .dat_en(dat_en), .req_valid(req_valid), .req_va(req_va),
      .req_kind(req_kind), .req_space(req_space), .desig_pri(desig_pri), .desig_sec(desig_sec),
      .desig_home(desig_home), .busy(busy), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .rsp_valid(rsp_valid),
      .rsp_real(rsp_real), .rsp_perm(rsp_perm), .rsp_fault(rsp_fault),
      .rsp_fault_word(rsp_fault_word));

   typedef struct packed {
      logic [63:0] va;
      logic [1:0]  kind;
      logic [1:0]  space;
      logic        dat;
      logic [2:0]  flt;
      logic [63:0] real_a;
      logic [2:0]  perm;
      logic [63:0] word;
      logic [7:0]  reads;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VEC [NV] = '{
      '{64'h403123,            2'd0, 2'd0, 1'b1, 3'd0, 64'hABCDE123,         3'b111, 64'h0,               8'd5},
      '{64'h405ABC,            2'd0, 2'd0, 1'b1, 3'd0, 64'h77ABC,            3'b101, 64'h0,               8'd5},
      '{64'h405ABC,            2'd1, 2'd0, 1'b1, 3'd1, 64'h0,                3'b000, 64'h405005,          8'd5},
      '{64'h406010,            2'd0, 2'd0, 1'b1, 3'd3, 64'h0,                3'b000, 64'h406001,          8'd5},
      '{64'h600000,            2'd0, 2'd0, 1'b1, 3'd2, 64'h0,                3'b000, 64'h600001,          8'd4},
      '{64'h700000,            2'd0, 2'd0, 1'b1, 3'd4, 64'h0,                3'b000, 64'h700001,          8'd4},
      '{64'h103456,            2'd0, 2'd1, 1'b1, 3'd0, 64'h12345456,         3'b110, 64'h0,               8'd2},
      '{64'h103456,            2'd1, 2'd1, 1'b1, 3'd0, 64'h12345456,         3'b110, 64'h0,               8'd2},
      '{64'h403123,            2'd2, 2'd1, 1'b1, 3'd0, 64'hABCDE123,         3'b001, 64'h0,               8'd5},
      '{64'h80000000,          2'd0, 2'd1, 1'b1, 3'd4, 64'h0,                3'b000, 64'h80000002,        8'd0},
      '{64'h12345678ABC,       2'd0, 2'd2, 1'b1, 3'd0, 64'h12345678ABC,      3'b111, 64'h0,               8'd0},
      '{64'h40000000000,       2'd0, 2'd2, 1'b1, 3'd4, 64'h0,                3'b000, 64'h40000000003,     8'd0},
      '{64'hFFFF000012345678,  2'd1, 2'd1, 1'b0, 3'd0, 64'hFFFF000012345678,  3'b111, 64'h0,               8'd0},
      '{64'h0060000000403001,  2'd0, 2'd0, 1'b1, 3'd4, 64'h0,                3'b000, 64'h0060000000403001, 8'd1},
      '{64'h7FFFF000,          2'd0, 2'd1, 1'b1, 3'd0, 64'h0,                3'b110, 64'h0,               8'd2}
   };
   localparam string TAG [NV] = '{"R5", "R8", "R9", "R8", "R6", "R7", "R10", "R10", "R10",
                                  "R3", "R4", "R12", "R2", "R7", "R3"};

   function automatic logic [63:0] lookup(input logic [63:0] a);
      lookup = mem.exists(a) ? mem[a] : 64'h0;
   endfunction

   task automatic check(input string tag, input string what, input logic [63:0] act,
                        input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic wait_rsp();
      for (int n = 0; n < 200 && !rsp_valid; n++) @(negedge clk);
   endtask

   // memory model: answers two cycles after a held read request
   initial begin
      int lat;
      lat = 0;
      mem_rd_valid = 1'b0;
      mem_rd_data  = 64'h0;
      forever begin
         @(negedge clk);
         if (mem_rd_valid) begin
            mem_rd_valid = 1'b0;
            lat = 0;
         end else if (mem_rd_en) begin
            lat++;
            if (lat == 2) begin
               mem_rd_valid = 1'b1;
               mem_rd_data  = lookup(mem_rd_addr);
               rd_count++;
            end
         end else begin
            lat = 0;
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R11 watchdog: actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int extra;
      dat_en = 1'b1; req_valid = 1'b0; req_va = '0; req_kind = '0; req_space = '0;
      desig_pri  = 64'h1000C;
      desig_sec  = 64'h80000;
      desig_home = 64'h24;
      mem[64'h10000] = 64'h20008;
      mem[64'h20000] = 64'h30004;
      mem[64'h30000] = 64'h40000;
      mem[64'h40020] = 64'h50000;
      mem[64'h40030] = 64'h20;
      mem[64'h40038] = 64'h60004;
      mem[64'h50018] = 64'hABCDE000;
      mem[64'h50028] = 64'h77200;
      mem[64'h50030] = 64'h400;
      mem[64'h80008] = 64'h90000;
      mem[64'h90018] = 64'h12345000;

      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1", "busy in reset", 64'(busy), 64'h0);
      check("R1", "rsp_valid in reset", 64'(rsp_valid), 64'h0);
      check("R1", "mem_rd_en in reset", 64'(mem_rd_en), 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "busy after reset", 64'(busy), 64'h0);

      for (int i = 0; i < NV; i++) begin
         vec_t v;
         v = VEC[i];
         @(negedge clk);
         rd_count  = 0;
         req_va    = v.va; req_kind = v.kind; req_space = v.space; dat_en = v.dat;
         req_valid = 1'b1;
         @(negedge clk);
         req_valid = 1'b0;
         wait_rsp();
         check(TAG[i], "rsp_valid", 64'(rsp_valid), 64'h1);
         check(TAG[i], "fault", 64'(rsp_fault), 64'(v.flt));
         check(TAG[i], "real", rsp_real, v.real_a);
         check(TAG[i], "perm", 64'(rsp_perm), 64'(v.perm));
         check(TAG[i], "fault word", rsp_fault_word, v.word);
         check(TAG[i], "table reads", 64'(rd_count), 64'(v.reads));
         dat_en = 1'b1;
      end

      // R5 first read address, R11 request ignored while busy
      @(negedge clk);
      req_va = 64'h403123; req_kind = 2'd0; req_space = 2'd0; req_valid = 1'b1;
      @(negedge clk);
      check("R5", "busy at walk start", 64'(busy), 64'h1);
      check("R5", "first read addr", mem_rd_addr, 64'h10000);
      req_va = 64'hDEAD000; dat_en = 1'b0;
      @(negedge clk);
      check("R11", "no response while busy", 64'(rsp_valid), 64'h0);
      req_valid = 1'b0; dat_en = 1'b1;
      wait_rsp();
      check("R11", "walk result kept", rsp_real, 64'hABCDE123);
      extra = 0;
      repeat (8) begin
         @(negedge clk);
         if (rsp_valid) extra++;
      end
      check("R11", "extra responses", 64'(extra), 64'h0);
      check("R11", "idle after walk", 64'(busy), 64'h0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule